// File: doc/BRIEF.md
# SPI Master for Register Bridge Transactions

This block runs one register access at a time against a serial register-bridge slave. A request gives a direction (read or write), a register address and, for a write, a data word. The block frames the request as one serial transaction: chip select goes low, an address field is shifted out, then a data field follows. During a write the master drives the data word. During a read it keeps its output low and collects the word the slave returns.

The frame's address field is one bit wider than the register address. Its leading bit gives the access type: 1 for a write, 0 for a read. The register address bits follow, most significant first. Every serial bit takes `CLK_RATIO` system clocks. The serial clock is low for the first half of each bit and high for the second half, so it idles low. The returned data is sampled at the half-bit point, which is where the serial clock rises. A request is taken over a valid/ready handshake. A one-cycle done pulse, carrying the read word, marks the release of chip select.

Top module: `regbus_spi_master`

## Requirements
- R1: After a synchronous reset, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `spi_cs_n` is 0 from the next cycle for exactly (ADDR_W+1+DATA_W)×CLK_RATIO cycles.
- R3: Within each bit period of a frame, `spi_sclk` is 0 for the first CLK_RATIO/2 cycles and 1 for the last CLK_RATIO/2 cycles. While `spi_cs_n` is 1, `spi_sclk` and `spi_mosi` are 0.
- R4: The first bit on `spi_mosi` is 1 for a write and 0 for a read. The ADDR_W bits of `req_addr` follow, most significant bit first, one per bit period.
- R5: On a write, the DATA_W bits of `req_wdata` follow the address field directly, most significant bit first.
- R6: On a read, `spi_mosi` is 0 for the whole data phase. `spi_miso` is sampled only in the first cycle of each data bit in which `spi_sclk` is 1. The sampled bits are assembled most significant bit first into `rsp_rdata`.
- R7: `rsp_done` is high for exactly one cycle: the first cycle in which `spi_cs_n` is 1 again after a frame. `rsp_rdata` then holds the read word, or zero after a write.
- R8: `req_ready` is 0 from acceptance until CLK_RATIO cycles after chip select is released. `spi_cs_n` therefore stays 1 for at least CLK_RATIO cycles between frames.
- R9: A reset during a frame drops the transaction. Chip select returns high, `spi_sclk` and `spi_mosi` go low, and no `rsp_done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read word (zero after a write) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
Reads and writes alternate over a table of vectors that covers these cases:
- A write whose address MSB is 0 and a read whose address MSB is 1. These show that the leading bit comes from the access type and not from the address.
- Data words of all ones, all zeros, alternating bits and single set bits at either end. These expose a wrong shift direction or an off-by-one bit count.

The model slave drives the correct data bit only in the half-bit cycle. It drives the inverted bit in every other cycle, so any shift of the sampling point corrupts the read word. Requests are issued back to back to measure the chip-select gap. A reset in the middle of a frame shows that the transaction is dropped.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } spim_state_e;
endpackage

// File: rtl/spim_bit_timer.sv
// Bit-period sequencer: phase counter inside a bit, bit index inside a frame,
// and the registered serial clock derived from the phase.
module spim_bit_timer #(
  parameter int RATIO = 8,
  parameter int NBITS = 40
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      run,
  output logic [$clog2(NBITS)-1:0]  bit_idx,
  output logic                      mid,
  output logic                      bit_end,
  output logic                      last_bit,
  output logic                      sclk
);
  localparam int PH_W = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam int BI_W = $clog2(NBITS);
  localparam logic [PH_W-1:0] PH_LAST    = PH_W'(RATIO - 1);
  localparam logic [PH_W-1:0] PH_MID     = PH_W'(RATIO / 2);
  localparam logic [PH_W-1:0] PH_PRE_MID = PH_W'(RATIO / 2 - 1);
  localparam logic [BI_W-1:0] BI_LAST    = BI_W'(NBITS - 1);

  logic [PH_W-1:0] phase;

  assign bit_end  = run && (phase == PH_LAST);
  assign mid      = run && (phase == PH_MID);
  assign last_bit = bit_end && (bit_idx == BI_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      bit_idx <= '0;
      sclk    <= 1'b0;
    end else if (start) begin
      phase   <= '0;
      bit_idx <= '0;
      sclk    <= 1'b0;
    end else if (run) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        sclk  <= 1'b0;
        if (bit_idx != BI_LAST) bit_idx <= bit_idx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
        if (phase == PH_PRE_MID) sclk <= 1'b1;
      end
    end
  end

  p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
    phase <= PH_LAST);
  p_sclk_high_at_mid_r3: assert property (@(posedge clk) disable iff (rst)
    mid |-> sclk);
  p_sclk_low_at_bit_start_r3: assert property (@(posedge clk) disable iff (rst)
    (run && phase == '0) |-> !sclk);
endmodule

// File: rtl/spim_tx_shift.sv
// Outgoing frame shifter; the serial output is a register.
module spim_tx_shift #(
  parameter int NBITS = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NBITS-1:0] load_word,
  input  logic             shift,
  input  logic             clear,
  output logic             mosi
);
  logic [NBITS-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      mosi <= 1'b0;
    end else if (load) begin
      mosi <= load_word[NBITS-1];
      sr   <= {load_word[NBITS-2:0], 1'b0};
    end else if (clear) begin
      mosi <= 1'b0;
      sr   <= '0;
    end else if (shift) begin
      mosi <= sr[NBITS-1];
      sr   <= {sr[NBITS-2:0], 1'b0};
    end
  end

  p_clear_drops_line_r3: assert property (@(posedge clk) disable iff (rst)
    (clear && !load) |=> !mosi);
endmodule

// File: rtl/spim_rx_shift.sv
// Incoming word collector, MSB first.
module spim_rx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         sample,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clear) word <= '0;
    else if (sample)  word <= {word[W-2:0], din};
  end

  p_sample_lands_lsb_r6: assert property (@(posedge clk) disable iff (rst)
    (sample && !clear) |=> (word[0] == $past(din)));
endmodule

// File: rtl/regbus_spi_master.sv
module regbus_spi_master
  import spim_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int CLK_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int FIELD_W   = ADDR_W + 1;
  localparam int NBITS     = FIELD_W + DATA_W;
  localparam int BI_W      = $clog2(NBITS);
  localparam int GC_W      = (CLK_RATIO > 2) ? $clog2(CLK_RATIO) : 1;
  localparam int FRAME_CYC = NBITS * CLK_RATIO;
  localparam int LC_W      = $clog2(FRAME_CYC + 1);
  localparam logic [GC_W-1:0] GAP_LAST   = GC_W'(CLK_RATIO - 1);
  localparam logic [BI_W-1:0] DATA_START = BI_W'(FIELD_W);

  if (CLK_RATIO < 2 || (CLK_RATIO % 2) != 0) begin : g_bad_ratio
    $error("CLK_RATIO must be an even integer of at least 2");
  end
  if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_width
    $error("ADDR_W must be >= 1 and DATA_W >= 2");
  end

  spim_state_e       state;
  logic [GC_W-1:0]   gap_cnt;
  logic              is_read;
  logic              accept;
  logic              run;
  logic [BI_W-1:0]   bit_idx;
  logic              mid, bit_end, last_bit;
  logic [NBITS-1:0]  frame_word;
  logic [DATA_W-1:0] rx_word;
  logic              rx_sample;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign run        = (state == ST_FRAME);
  assign frame_word = {req_write, req_addr, (req_write ? req_wdata : {DATA_W{1'b0}})};
  assign rx_sample  = run && is_read && mid && (bit_idx >= DATA_START);

  spim_bit_timer #(.RATIO(CLK_RATIO), .NBITS(NBITS)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .run      (run),
    .bit_idx  (bit_idx),
    .mid      (mid),
    .bit_end  (bit_end),
    .last_bit (last_bit),
    .sclk     (spi_sclk)
  );

  spim_tx_shift #(.NBITS(NBITS)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_word (frame_word),
    .shift     (bit_end && !last_bit),
    .clear     (last_bit),
    .mosi      (spi_mosi)
  );

  spim_rx_shift #(.W(DATA_W)) rx_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .sample (rx_sample),
    .din    (spi_miso),
    .word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      spi_cs_n  <= 1'b1;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      is_read   <= 1'b0;
      gap_cnt   <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_FRAME;
            spi_cs_n <= 1'b0;
            is_read  <= !req_write;
          end
        end
        ST_FRAME: begin
          if (last_bit) begin
            state     <= ST_GAP;
            spi_cs_n  <= 1'b1;
            rsp_done  <= 1'b1;
            rsp_rdata <= is_read ? rx_word : '0;
            gap_cnt   <= '0;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_LAST) state <= ST_IDLE;
          else                     gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker-side counter of consecutive chip-select-low cycles.
  logic [LC_W-1:0] cs_low_cnt;
  always_ff @(posedge clk) begin
    if (rst || spi_cs_n) cs_low_cnt <= '0;
    else                 cs_low_cnt <= cs_low_cnt + 1'b1;
  end

  p_frame_length_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (cs_low_cnt == LC_W'(FRAME_CYC)));
  p_frame_bound_r2: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> (cs_low_cnt < LC_W'(FRAME_CYC)));
  p_idle_lines_low_r3: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> (!spi_sclk && !spi_mosi));
  p_type_marker_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (spi_mosi == !is_read));
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  p_done_at_release_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $rose(spi_cs_n));
  p_ready_only_idle_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> spi_cs_n);
  p_no_ready_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !req_ready);
endmodule

// File: tb/regbus_spi_master_tb_top.sv
module regbus_spi_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int DW = 32;
  localparam int R  = 8;
  localparam int AF = AW + 1;
  localparam int NB = AF + DW;
  localparam int FRAME = NB * R;
  localparam int NVEC = 8;

  // {write, addr, wdata, slave word}
  localparam logic [1+AW+DW+DW-1:0] VEC [NVEC] = '{
    {1'b1, 7'h25, 32'hDEADBEEF, 32'h0000_0000},
    {1'b0, 7'h3C, 32'h0000_0000, 32'h1234_5678},
    {1'b1, 7'h01, 32'h0000_0001, 32'h0000_0000},
    {1'b0, 7'h7F, 32'h0000_0000, 32'h8000_0001},
    {1'b1, 7'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b0, 7'h40, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 7'h55, 32'h0000_0000, 32'hFFFF_FFFF},
    {1'b1, 7'h6A, 32'hA5A5_5A5A, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic spi_miso = 1'b0;
  logic req_ready, rsp_done, spi_sclk, spi_cs_n, spi_mosi;
  logic [DW-1:0] rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbus_spi_master #(.ADDR_W(AW), .DATA_W(DW), .CLK_RATIO(R)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Slave model / line monitor state
  logic [DW-1:0] slave_word = '0;
  logic [NB-1:0] mosi_cap = '0;
  int low_k = 0, high_k = 0, last_len = 0, gap_min = 1000000;
  int shape_err = 0, idle_err = 0, rdy_err = 0;
  bit seen_frame = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      low_k = 0; high_k = 0; spi_miso = 1'b0;
    end else if (!spi_cs_n) begin
      int ph, bn;
      logic b;
      ph = low_k % R;
      bn = low_k / R;
      if (low_k == 0 && seen_frame && high_k < gap_min) gap_min = high_k;
      high_k = 0;
      if (spi_sclk != (ph >= R/2)) shape_err++;
      if (req_ready) rdy_err++;
      if (ph == R/2 && bn < NB) mosi_cap = {mosi_cap[NB-2:0], spi_mosi};
      if (bn >= AF && bn < NB) begin
        b = slave_word[DW-1-(bn-AF)];
        spi_miso = (ph == R/2) ? b : ~b;
      end else spi_miso = 1'b0;
      low_k++;
    end else begin
      if (low_k != 0) begin last_len = low_k; low_k = 0; seen_frame = 1; end
      if (spi_sclk || spi_mosi) idle_err++;
      high_k++;
      spi_miso = 1'b0;
    end
  end

  task automatic step;
    @(posedge clk); #2;
  endtask

  task automatic run_txn(input logic wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic [DW-1:0] sw);
    logic [NB-1:0] exp_frame;
    int t;
    while (!req_ready) step();
    slave_word = sw; mosi_cap = '0; shape_err = 0; idle_err = 0; rdy_err = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    step();
    req_valid = 1'b0;
    t = 0;
    while (!rsp_done && t < 2*FRAME) begin step(); t++; end
    chk(rsp_done, "R7 done seen", 64'(rsp_done), 64'd1);
    chk(rsp_rdata == (wr ? '0 : sw), wr ? "R7 rdata zero after write" : "R6 read word",
        64'(rsp_rdata), 64'(wr ? '0 : sw));
    chk(spi_cs_n, "R7 cs high with done", 64'(spi_cs_n), 64'd1);
    @(negedge clk); #1;
    exp_frame = {wr, a, (wr ? wd : {DW{1'b0}})};
    chk(last_len == FRAME, "R2 frame length", 64'(last_len), 64'(FRAME));
    chk(shape_err == 0, "R3 sclk shape", 64'(shape_err), 64'd0);
    chk(mosi_cap[NB-1:DW] == exp_frame[NB-1:DW], "R4 address field",
        64'(mosi_cap[NB-1:DW]), 64'(exp_frame[NB-1:DW]));
    chk(mosi_cap[DW-1:0] == exp_frame[DW-1:0], wr ? "R5 write data" : "R6 mosi low in data",
        64'(mosi_cap[DW-1:0]), 64'(exp_frame[DW-1:0]));
    chk(rdy_err == 0, "R8 ready low in frame", 64'(rdy_err), 64'd0);
    step();
    chk(!rsp_done, "R7 done one cycle", 64'(rsp_done), 64'd0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state
    chk(spi_cs_n == 1'b1, "R1 cs_n reset", 64'(spi_cs_n), 64'd1);
    chk(spi_sclk == 1'b0, "R1 sclk reset", 64'(spi_sclk), 64'd0);
    chk(spi_mosi == 1'b0, "R1 mosi reset", 64'(spi_mosi), 64'd0);
    chk(rsp_done == 1'b0, "R1 done reset", 64'(rsp_done), 64'd0);
    chk(req_ready == 1'b1, "R1 ready reset", 64'(req_ready), 64'd1);

    for (int i = 0; i < NVEC; i++) begin
      run_txn(VEC[i][1+AW+DW+DW-1], VEC[i][AW+DW+DW-1:DW+DW],
              VEC[i][DW+DW-1:DW], VEC[i][DW-1:0]);
    end
    chk(gap_min >= R, "R8 cs gap between frames", 64'(gap_min), 64'(R));
    chk(idle_err == 0, "R3 idle lines low", 64'(idle_err), 64'd0);

    // R9: reset in the middle of a frame
    while (!req_ready) step();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 7'h12; req_wdata = 32'hCAFE_F00D;
    step();
    req_valid = 1'b0;
    repeat (50) step();
    chk(!spi_cs_n, "R9 frame active before reset", 64'(spi_cs_n), 64'd0);
    rst = 1'b1;
    step();
    chk(spi_cs_n && !spi_sclk && !spi_mosi, "R9 lines idle after reset",
        64'({spi_cs_n, spi_sclk, spi_mosi}), 64'b100);
    step();
    rst = 1'b0;
    begin
      int dones = 0, lows = 0;
      for (int c = 0; c < 2*FRAME; c++) begin
        step();
        if (rsp_done) dones++;
        if (!spi_cs_n) lows++;
      end
      chk(dones == 0, "R9 no done after dropped frame", 64'(dones), 64'd0);
      chk(lows == 0, "R9 cs stays high", 64'(lows), 64'd0);
    end
    chk(req_ready, "R9 ready after reset", 64'(req_ready), 64'd1);
    run_txn(1'b0, 7'h2B, 32'h0, 32'h0F0F_1E1E);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "R2 watchdog expired", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule